// File: doc/BRIEF.md
# Segmented Radix/Thermometer Weight Calibrator

This block corrects the static transfer curve of an N-bit analog-to-digital converter in the digital domain. It splits each raw code into two parts. The low M bits are weighted per bit, so each carries one adaptive radix factor. The high N−M bits are expanded into a thermometer vector, and each active element adds its own adaptive weight. The corrected value is the sum of these contributions, expressed in converter LSBs with FRAC fractional bits. With the defaults N=10 and M=4, the block holds 67 weights: 63 thermometer weights and 4 radix weights. A full per-code table would need 1023.

During a foreground calibration phase, a known reference value is supplied with every sample. The block forms one error, reference minus corrected output. A least-mean-squares step then moves every weight that the sample touched. The step size is a programmable right shift. Once the error has settled, the mode is switched to run. The weights are then frozen and applied to every later sample.

Top module: `hcal_top`

## Requirements
- R1: While rst_n is low, out_valid, corr_out and err_out are cleared to 0 at every clock edge.
- R2: Thermometer weights reset to 2^(M+FRAC), which is 256 with the defaults, and radix weights reset to 2^FRAC, which is 16. Before any calibration, corr_out therefore equals raw_code·2^FRAC. out_valid is high exactly one cycle after an accepted sample (in_valid high).
- R3: err_out is the reference of a sample minus its corrected value. It appears in the same cycle as corr_out for that sample.
- R4: In run mode (mode = 0), no weight changes. The same raw code gives the same corr_out whatever reference or other codes come between.
- R5: In calibrate mode (mode = 1), each set LSB bit i (bit 0 is the least significant) adds floor(e / 2^(mu_shift+i)) to radix weight i. Radix weight i contributes α_i·2^i to the output.
- R6: The high segment value m = raw_code[N−1:M] activates thermometer elements 0..m−1. In calibrate mode, each active element adds floor(e / 2^mu_shift) to its weight. Each active element contributes its weight to the output.
- R7: Weights saturate at their signed limits instead of wrapping. Thermometer weights are TW = M+FRAC+3 bits wide, giving −1024..1023. Radix weights are FRAC+3 bits wide, giving −64..63.
- R8: A weight update made for one sample is already in use for the next accepted sample, even in the following cycle.
- R9: When in_valid is low, no weight changes, out_valid is low in the next cycle, and corr_out and err_out hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present on raw_code/ref_val |
| mode | input | 1 | 1 = calibrate (adapt weights), 0 = run (weights frozen) |
| mu_shift | input | MUW (5) | Step size as a right shift of the error |
| raw_code | input | N (10) | Raw converter code |
| ref_val | input | SW (19) | Signed reference, LSB·2^FRAC units |
| out_valid | output | 1 | corr_out/err_out updated for a sample |
| corr_out | output | SW (19) | Signed corrected value |
| err_out | output | SW+1 (20) | Signed reference minus corrected value |

## Verification
A wrong radix weight shows up as a corr_out offset on every later code with that bit set. A wrong thermometer weight shows up as an offset on every code whose high segment reaches past that element. Either fault appears one cycle after the first sample that uses the weight. The bench runs a model of every weight beside the design and compares corr_out and err_out on every sample. A bad update, a missed freeze or a wrapped saturation therefore shows up on the next sample that touches the weight. In run mode, a repeated code must give identical output.

// File: rtl/hcal_pkg.sv
// Shared types for the segmented calibrator.
package hcal_pkg;
    typedef enum logic {
        MODE_RUN = 1'b0,
        MODE_CAL = 1'b1
    } hcal_mode_e;
endpackage

// File: rtl/hcal_therm.sv
// Binary to thermometer expander for the high code segment.
// Element j is set when the binary value exceeds j; assumes NT is small (<= 8).
module hcal_therm #(
    parameter int NT = 6,
    localparam int NTH = (1 << NT) - 1
) (
    input  logic [NT-1:0]  bin,
    output logic [NTH-1:0] therm
);
    genvar j;
    generate
        for (j = 0; j < NTH; j++) begin : g_cmp
            // one comparator per element
            assign therm[j] = (int'(bin) > j);
        end
    endgenerate

    // check that the element count tracks the binary value
    always_comb begin
        if (!$isunknown(bin)) begin
            a_r6_therm_count: assert ($countones(therm) == int'(bin));
        end
    end
endmodule

// File: rtl/hcal_wcell.sv
// One adaptive weight: a saturating accumulator.
// Adds delta when en is high and clamps at the signed W-bit limits.
// Assumes DW >= W.
module hcal_wcell #(
    parameter int W = 11,
    parameter int DW = 20,
    parameter logic signed [W-1:0] INIT = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] delta,
    output logic signed [W-1:0]  w
);
    localparam logic signed [DW:0] MAXV = {{(DW+2-W){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [DW:0] MINV = {{(DW+2-W){1'b1}}, {(W-1){1'b0}}};

    logic signed [DW:0] sum_w;
    logic signed [W-1:0] next_w;

    // widen and add without overflow
    always_comb begin
        sum_w = $signed({{(DW+1-W){w[W-1]}}, w}) + $signed({delta[DW-1], delta});
    end

    // clamp to the weight range
    always_comb begin
        if (sum_w > MAXV)      next_w = MAXV[W-1:0];
        else if (sum_w < MINV) next_w = MINV[W-1:0];
        else                   next_w = sum_w[W-1:0];
    end

    // weight register
    always_ff @(posedge clk) begin
        if (!rst_n)  w <= INIT;
        else if (en) w <= next_w;
    end

    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(w));
    a_r7_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !delta[DW-1]) |=> (w >= $past(w)));
    a_r7_no_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (en && delta[DW-1]) |=> (w <= $past(w)));
endmodule

// File: rtl/hcal_accum.sv
// Sums the active thermometer weights and the shifted radix weights.
// Purely combinational; assumes SW is wide enough for the worst-case sum.
module hcal_accum #(
    parameter int M = 4,
    parameter int NTH = 63,
    parameter int TW = 11,
    parameter int AW = 7,
    parameter int SW = 19
) (
    input  logic [NTH-1:0]       therm,
    input  logic [M-1:0]         lsb,
    input  logic signed [TW-1:0] beta [NTH],
    input  logic signed [AW-1:0] alpha [M],
    output logic signed [SW-1:0] y
);
    // accumulate both segments
    always_comb begin
        y = '0;
        for (int j = 0; j < NTH; j++) begin
            if (therm[j]) y = y + SW'(beta[j]);
        end
        for (int i = 0; i < M; i++) begin
            if (lsb[i]) y = y + (SW'(alpha[i]) <<< i);
        end
    end
endmodule

// File: rtl/hcal_top.sv
// Segmented radix/thermometer calibrator with LMS adaptation.
// Low M bits use per-bit radix weights and high N-M bits use thermometer weights.
// In calibrate mode, one shared error moves every touched weight.
// Output and error are registered, with one cycle of latency.
module hcal_top #(
    parameter int N = 10,
    parameter int M = 4,
    parameter int FRAC = 4,
    parameter int MUW = 5,
    localparam int NT = N - M,
    localparam int NTH = (1 << NT) - 1,
    localparam int TW = M + FRAC + 3,
    localparam int AW = FRAC + 3,
    localparam int SW = TW + NT + 2,
    localparam int ES = SW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 mode,
    input  logic [MUW-1:0]       mu_shift,
    input  logic [N-1:0]         raw_code,
    input  logic signed [SW-1:0] ref_val,
    output logic                 out_valid,
    output logic signed [SW-1:0] corr_out,
    output logic signed [ES-1:0] err_out
);
    import hcal_pkg::*;

    logic [NT-1:0]       msb_code;
    logic [M-1:0]        lsb_code;
    logic [NTH-1:0]      therm;
    logic signed [TW-1:0] beta_w [NTH];
    logic signed [AW-1:0] alpha_w [M];
    logic signed [SW-1:0] y_now;
    logic signed [ES-1:0] err_now;
    logic signed [ES-1:0] dlt_b;
    logic signed [ES-1:0] dlt_a [M];
    logic                 cal_go;

    assign msb_code = raw_code[N-1:M];
    assign lsb_code = raw_code[M-1:0];
    assign cal_go   = in_valid && (mode == MODE_CAL);

    hcal_therm #(.NT(NT)) u_therm (
        .bin   (msb_code),
        .therm (therm)
    );

    hcal_accum #(.M(M), .NTH(NTH), .TW(TW), .AW(AW), .SW(SW)) u_accum (
        .therm (therm),
        .lsb   (lsb_code),
        .beta  (beta_w),
        .alpha (alpha_w),
        .y     (y_now)
    );

    // shared error and scaled step
    always_comb begin
        err_now = ES'(ref_val) - ES'(y_now);
        dlt_b   = err_now >>> mu_shift;
    end

    genvar j, i;
    generate
        for (j = 0; j < NTH; j++) begin : g_beta
            hcal_wcell #(.W(TW), .DW(ES), .INIT(TW'(1 << (M + FRAC)))) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (cal_go & therm[j]),
                .delta (dlt_b),
                .w     (beta_w[j])
            );
        end
        for (i = 0; i < M; i++) begin : g_alpha
            // radix step is further divided by 2^i
            assign dlt_a[i] = dlt_b >>> i;
            hcal_wcell #(.W(AW), .DW(ES), .INIT(AW'(1 << FRAC))) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (cal_go & lsb_code[i]),
                .delta (dlt_a[i]),
                .w     (alpha_w[i])
            );
        end
    endgenerate

    // output registers, updated on accepted samples only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            corr_out  <= '0;
            err_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                corr_out <= y_now;
                err_out  <= err_now;
            end
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && corr_out == '0 && err_out == '0));
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r3_err_match: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (err_out == ES'($past(ref_val)) - ES'(corr_out)));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(corr_out) && $stable(err_out)));
endmodule

// File: tb/sim_hcal_top.sv
// Bench for hcal_top: random calibration traffic plus directed corners.
// Every output is compared against a weight model kept in the bench.
module sim_hcal_top;
    localparam int TMAX = 1023, TMIN = -1024, AMAX = 63, AMIN = -64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic mode = 1'b0;
    logic [4:0] mu_shift = '0;
    logic [9:0] raw_code = '0;
    logic signed [18:0] ref_val = '0;
    logic out_valid;
    logic signed [18:0] corr_out;
    logic signed [19:0] err_out;

    int n_tests = 0;
    int n_fail = 0;
    int mb [63];
    int ma [4];
    int exp_c = 0, exp_e = 0;
    bit exp_v = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hcal_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .mu_shift(mu_shift), .raw_code(raw_code), .ref_val(ref_val),
        .out_valid(out_valid), .corr_out(corr_out), .err_out(err_out)
    );

    function automatic int clampi(int v, int lo, int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic void model_reset();
        for (int j = 0; j < 63; j++) mb[j] = 256;
        for (int i = 0; i < 4; i++) ma[i] = 16;
        exp_c = 0; exp_e = 0; exp_v = 0;
    endfunction

    function automatic int model_y(int code);
        int y = 0;
        for (int j = 0; j < (code >> 4); j++) y += mb[j];
        for (int i = 0; i < 4; i++) if (code[i]) y += ma[i] * (1 << i);
        return y;
    endfunction

    function automatic void model_update(int code, int e, int mu);
        int db = e >>> mu;
        for (int j = 0; j < (code >> 4); j++) mb[j] = clampi(mb[j] + db, TMIN, TMAX);
        for (int i = 0; i < 4; i++) if (code[i]) ma[i] = clampi(ma[i] + (db >>> i), AMIN, AMAX);
    endfunction

    task automatic chk(bit ok, string rq, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
        end
    endtask

    // drive one sample at a negedge, check outputs just after the next posedge
    task automatic step(bit v, bit md, int mu, int code, int rf, string rq);
        in_valid = v; mode = md; mu_shift = mu[4:0];
        raw_code = code[9:0]; ref_val = rf[18:0];
        if (v) begin
            exp_c = model_y(code);
            exp_e = rf - exp_c;
            if (md) model_update(code, exp_e, mu);
        end
        exp_v = v;
        @(posedge clk); #2;
        chk(out_valid == exp_v, {rq, " valid"}, int'(out_valid), int'(exp_v));
        chk(int'(corr_out) == exp_c, {rq, " corr"}, int'(corr_out), exp_c);
        chk(int'(err_out) == exp_e, {rq, " err"}, int'(err_out), exp_e);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        chk(!out_valid && corr_out == 0 && err_out == 0, "R1 reset clear",
            int'(corr_out), 0);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int target(int code);
        return code * 16 + ((code * code) >>> 8) - 30;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int c1, c2;
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();

        // R2: identity before calibration, including code extremes
        step(1, 0, 3, 0, 5, "R2 identity zero");
        step(1, 0, 3, 1023, 0, "R2 identity max");
        for (int k = 0; k < 20; k++) begin
            c1 = $urandom_range(0, 1023);
            step(1, 0, 3, c1, $urandom_range(0, 20000), "R2 identity rand");
            chk(int'(corr_out) == c1 * 16, "R2 code*16", int'(corr_out), c1 * 16);
        end

        // R9: idle cycles hold outputs
        step(0, 1, 0, 1023, 100000, "R9 idle hold");
        step(0, 0, 2, 5, -3, "R9 idle hold 2");

        // R5/R6/R8/R3: random calibration traffic
        for (int k = 0; k < 600; k++) begin
            c1 = $urandom_range(0, 1023);
            step(1, 1, $urandom_range(1, 6), c1,
                 target(c1) + $urandom_range(0, 3), "R5 R6 R8 cal");
            if ($urandom_range(0, 9) == 0) step(0, 1, 2, c1, 0, "R9 gap");
        end

        // R5: low bits only, back to back
        for (int k = 0; k < 20; k++) begin
            c1 = $urandom_range(1, 15);
            step(1, 1, 1, c1, target(c1) + 9, "R5 lsb only");
        end

        // R4: run mode keeps weights; repeat a code around other traffic
        c1 = 700;
        step(1, 0, 0, c1, 0, "R4 first");
        c2 = int'(corr_out);
        for (int k = 0; k < 10; k++)
            step(1, 0, 0, $urandom_range(0, 1023), 200000, "R4 run traffic");
        step(1, 0, 0, c1, -50000, "R4 repeat");
        chk(int'(corr_out) == c2, "R4 unchanged", int'(corr_out), c2);

        // R7: drive to positive saturation, then negative
        for (int k = 0; k < 8; k++) step(1, 1, 0, 1023, 262143, "R7 sat high");
        step(1, 0, 0, 1023, 0, "R7 sat high read");
        chk(int'(corr_out) == 63 * TMAX + AMAX * 15, "R7 max sum",
            int'(corr_out), 63 * TMAX + AMAX * 15);
        for (int k = 0; k < 8; k++) step(1, 1, 0, 1023, -262144, "R7 sat low");
        step(1, 0, 0, 1023, 0, "R7 sat low read");
        chk(int'(corr_out) == 63 * TMIN + AMIN * 15, "R7 min sum",
            int'(corr_out), 63 * TMIN + AMIN * 15);

        // R1/R2: reset restores the ideal weights
        @(negedge clk);
        do_reset();
        step(1, 0, 0, 1023, 0, "R2 after reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule